// File: doc/BRIEF.md
# Snooping Invalidate Cache Controller

This block keeps a small direct-mapped write-back cache coherent on a shared snooping bus. Each line carries a tag, one data word and a three-way coherence state: Invalid, Shared (clean and readable) or Exclusive (the only copy, writable and dirty). Processor reads and writes are looked up in the line array. A hit completes locally. A miss issues a command on the shared bus through a single-owner valid/ready handshake, then waits for the fill word.

The same line state also answers the bus side. Every transaction that another cache places on the bus is presented on the snoop input. A snooped write miss removes a clean copy. A snooped miss that finds this cache holding the dirty copy raises an abort so that memory does not answer. The block then pushes its copy out as a write-back and drops the line to Shared or Invalid.

Snoops and processor requests share one lookup stage. A snoop always wins that stage, and the processor request stalls until the snoop has finished. All traffic passes through the one bus, so every cache sees the writes to a given address in the same order.

Top module: `snoop_cache_ctrl`

## Requirements
- R1: After synchronous reset every line is Invalid, `bus_req_valid`, `cpu_done` and `snp_abort` are low, and `cpu_ready` and `snp_ready` are high.
- R2: A processor read whose line is Invalid, or holds another tag, issues a read miss (op 01) carrying the request address. One cycle after the fill word arrives on `bus_fill_valid`, `cpu_done` pulses with that word and the line becomes Shared.
- R3: A processor write to a line that is Invalid, Shared or holds another tag issues a write miss (op 10) carrying the request address. After the fill, `cpu_done` pulses with the written word and the line becomes Exclusive.
- R4: A read that hits a Shared or Exclusive line, or a write that hits an Exclusive line, raises `cpu_done` in the cycle after acceptance and places no command on the bus. The line state does not change, and a write replaces the stored word.
- R5: A miss whose indexed line is Exclusive under a different tag first issues a write-back (op 11) with the victim's address and data. The read or write miss follows it.
- R6: A snooped write miss that matches a Shared line makes the line Invalid, with no abort and no bus command.
- R7: A snooped read miss that matches an Exclusive line raises `snp_abort` in the cycle the snoop is accepted. In the following cycle the block issues a write-back of the snooped address with the line's data, and the line then becomes Shared.
- R8: A snooped write miss that matches an Exclusive line aborts and writes back in the same way as R7, and the line then becomes Invalid.
- R9: When `snp_valid` is high, `cpu_ready` is low, so a snoop always takes the lookup stage ahead of a processor request.
- R10: A snoop that finds no matching line, or a snooped read miss on a Shared line, changes no state and raises no abort.
- R11: While `bus_req_valid` is high and `bus_req_ready` is low, the command op, address and data stay unchanged.
- R12: `cpu_done` is high only in cycles when no bus command is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Line address of the request (low bits select the line) |
| cpu_wdata | input | DATA_W | Write word |
| cpu_ready | output | 1 | Request accepted this cycle when high together with cpu_valid |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read word, or the written word for a write, valid with cpu_done |
| bus_req_valid | output | 1 | Bus command pending |
| bus_req_ready | input | 1 | Bus grant; the command is taken when high with bus_req_valid |
| bus_req_op | output | 2 | 00 none, 01 read miss, 10 write miss, 11 write-back |
| bus_req_addr | output | ADDR_W | Command address |
| bus_req_data | output | DATA_W | Write-back data |
| bus_fill_valid | input | 1 | Fill word for the outstanding miss |
| bus_fill_data | input | DATA_W | Fill word |
| snp_valid | input | 1 | Snooped bus transaction present |
| snp_op | input | 2 | Snooped op, same encoding as bus_req_op |
| snp_addr | input | ADDR_W | Snooped address |
| snp_ready | output | 1 | Snoop accepted this cycle when high together with snp_valid |
| snp_abort | output | 1 | This cache owns the dirty copy; memory must not answer |

## Verification
Line state has no direct view at the ports. A wrong state therefore shows up at the next access to that line, as the wrong bus command. A line left Shared when it should be Invalid lets a later read hit with no read miss on the bus. A line that should have been Exclusive turns a write hit into a needless write miss. A dirty line that was lost shows as a missing abort on the next snoop, or as a missing write-back when the line is replaced. The bench therefore follows each snoop and each fill with a processor access or a snoop to the same line. This exposes the state within a few cycles, and the bus address and data are compared against a behavioural model of every line.

// File: rtl/snp_pkg.sv
package snp_pkg;

    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_EXC = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        CMD_NONE   = 2'b00,
        CMD_RDMISS = 2'b01,
        CMD_WRMISS = 2'b10,
        CMD_WBACK  = 2'b11
    } bus_op_e;

    typedef enum logic [2:0] {
        CT_IDLE,
        CT_WBACK,
        CT_MISS,
        CT_FILL,
        CT_SWB
    } ctl_st_e;

    // Processor access completes without the bus
    function automatic logic cpu_local_hit(line_st_e st, logic match, logic wr);
        return match && ((st == LN_EXC) || ((st == LN_SHR) && !wr));
    endfunction

    // State after a snooped transaction matched this line
    function automatic line_st_e snoop_next(line_st_e st, bus_op_e op);
        line_st_e nx;
        nx = st;
        if (st != LN_INV) begin
            if (op == CMD_WRMISS)
                nx = LN_INV;
            else if ((op == CMD_RDMISS) && (st == LN_EXC))
                nx = LN_SHR;
        end
        return nx;
    endfunction

    function automatic line_st_e fill_state(logic wr);
        return wr ? LN_EXC : LN_SHR;
    endfunction

endpackage

// File: rtl/snp_line_array.sv
module snp_line_array
    import snp_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int TAG_W  = 10,
    parameter int DATA_W = 32,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx_a,
    input  logic [IDX_W-1:0]  rd_idx_b,
    output line_st_e          a_st,
    output logic [TAG_W-1:0]  a_tag,
    output logic [DATA_W-1:0] a_data,
    output line_st_e          b_st,
    output logic [TAG_W-1:0]  b_tag,
    output logic [DATA_W-1:0] b_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  line_st_e          wr_st,
    input  logic              wr_tag_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic              wr_data_en,
    input  logic [DATA_W-1:0] wr_data
);

    line_st_e          st_v  [LINES];
    logic [TAG_W-1:0]  tag_v [LINES];
    logic [DATA_W-1:0] dat_v [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        line_st_e          st_q;
        logic [TAG_W-1:0]  tag_q;
        logic [DATA_W-1:0] dat_q;
        logic              sel;

        assign sel = wr_en && (wr_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                st_q  <= LN_INV;
                tag_q <= '0;
                dat_q <= '0;
            end else if (sel) begin
                st_q <= wr_st;
                if (wr_tag_en)
                    tag_q <= wr_tag;
                if (wr_data_en)
                    dat_q <= wr_data;
            end
        end

        assign st_v[g]  = st_q;
        assign tag_v[g] = tag_q;
        assign dat_v[g] = dat_q;
    end

    assign a_st   = st_v[rd_idx_a];
    assign a_tag  = tag_v[rd_idx_a];
    assign a_data = dat_v[rd_idx_a];
    assign b_st   = st_v[rd_idx_b];
    assign b_tag  = tag_v[rd_idx_b];
    assign b_data = dat_v[rd_idx_b];

endmodule

// File: rtl/snp_tag_cmp.sv
module snp_tag_cmp
    import snp_pkg::*;
#(
    parameter int TAG_W = 10
) (
    input  line_st_e         line_st,
    input  logic [TAG_W-1:0] line_tag,
    input  logic [TAG_W-1:0] want_tag,
    output logic             match,
    output logic             held_dirty
);

    assign match      = (line_st != LN_INV) && (line_tag == want_tag);
    assign held_dirty = (line_st == LN_EXC);

endmodule

// File: rtl/snp_bus_drive.sv
module snp_bus_drive
    import snp_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 2,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  ctl_st_e           ctl,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [TAG_W-1:0]  victim_tag,
    input  logic [ADDR_W-1:0] swb_addr,
    input  logic [DATA_W-1:0] victim_data,
    input  logic [DATA_W-1:0] swb_data,
    output logic              cmd_valid,
    output bus_op_e           cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data
);

    always_comb begin
        cmd_valid = 1'b0;
        cmd_op    = CMD_NONE;
        cmd_addr  = '0;
        cmd_data  = '0;
        unique case (ctl)
            CT_WBACK: begin
                cmd_valid = 1'b1;
                cmd_op    = CMD_WBACK;
                cmd_addr  = {victim_tag, req_addr[IDX_W-1:0]};
                cmd_data  = victim_data;
            end
            CT_MISS: begin
                cmd_valid = 1'b1;
                cmd_op    = req_wr ? CMD_WRMISS : CMD_RDMISS;
                cmd_addr  = req_addr;
            end
            CT_SWB: begin
                cmd_valid = 1'b1;
                cmd_op    = CMD_WBACK;
                cmd_addr  = swb_addr;
                cmd_data  = swb_data;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/snoop_cache_ctrl.sv
module snoop_cache_ctrl
    import snp_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int LINES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_valid,
    input  logic              cpu_write,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req_valid,
    input  logic              bus_req_ready,
    output logic [1:0]        bus_req_op,
    output logic [ADDR_W-1:0] bus_req_addr,
    output logic [DATA_W-1:0] bus_req_data,
    input  logic              bus_fill_valid,
    input  logic [DATA_W-1:0] bus_fill_data,
    input  logic              snp_valid,
    input  logic [1:0]        snp_op,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_ready,
    output logic              snp_abort
);

    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;
    localparam int TAG_W = ADDR_W - IDX_W;

    ctl_st_e           ctl_q, ctl_d;
    logic              req_wr_q;
    logic [ADDR_W-1:0] req_addr_q;
    logic [DATA_W-1:0] req_wdata_q;
    logic [ADDR_W-1:0] swb_addr_q;
    bus_op_e           swb_op_q;
    logic              done_q;
    logic [DATA_W-1:0] rdata_q;

    logic [IDX_W-1:0]  idx_a, idx_b;
    line_st_e          a_st, b_st;
    logic [TAG_W-1:0]  a_tag, b_tag;
    logic [DATA_W-1:0] a_data, b_data;
    logic [TAG_W-1:0]  want_a, want_b;
    logic              a_match, a_dirty, b_match, b_dirty;

    logic              wr_en, wr_tag_en, wr_data_en;
    logic [IDX_W-1:0]  wr_idx;
    line_st_e          wr_st;
    logic [TAG_W-1:0]  wr_tag;
    logic [DATA_W-1:0] wr_data;

    logic              in_idle, cpu_fire, snp_fire, cmd_fire;
    logic              cpu_hit, victim_dirty, snp_owns;
    bus_op_e           snp_op_e;
    bus_op_e           cmd_op;

    assign in_idle  = (ctl_q == CT_IDLE);
    assign snp_op_e = bus_op_e'(snp_op);

    // Port A serves the processor side, port B the snoop side
    assign idx_a  = in_idle ? cpu_addr[IDX_W-1:0] : req_addr_q[IDX_W-1:0];
    assign idx_b  = in_idle ? snp_addr[IDX_W-1:0] : swb_addr_q[IDX_W-1:0];
    assign want_a = in_idle ? cpu_addr[ADDR_W-1:IDX_W] : req_addr_q[ADDR_W-1:IDX_W];
    assign want_b = in_idle ? snp_addr[ADDR_W-1:IDX_W] : swb_addr_q[ADDR_W-1:IDX_W];

    snp_line_array #(
        .LINES (LINES),
        .TAG_W (TAG_W),
        .DATA_W(DATA_W)
    ) u_array (
        .clk       (clk),
        .rst       (rst),
        .rd_idx_a  (idx_a),
        .rd_idx_b  (idx_b),
        .a_st      (a_st),
        .a_tag     (a_tag),
        .a_data    (a_data),
        .b_st      (b_st),
        .b_tag     (b_tag),
        .b_data    (b_data),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_st     (wr_st),
        .wr_tag_en (wr_tag_en),
        .wr_tag    (wr_tag),
        .wr_data_en(wr_data_en),
        .wr_data   (wr_data)
    );

    snp_tag_cmp #(.TAG_W(TAG_W)) u_cmp_cpu (
        .line_st   (a_st),
        .line_tag  (a_tag),
        .want_tag  (want_a),
        .match     (a_match),
        .held_dirty(a_dirty)
    );

    snp_tag_cmp #(.TAG_W(TAG_W)) u_cmp_snp (
        .line_st   (b_st),
        .line_tag  (b_tag),
        .want_tag  (want_b),
        .match     (b_match),
        .held_dirty(b_dirty)
    );

    snp_bus_drive #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .IDX_W (IDX_W)
    ) u_drive (
        .ctl        (ctl_q),
        .req_wr     (req_wr_q),
        .req_addr   (req_addr_q),
        .victim_tag (a_tag),
        .swb_addr   (swb_addr_q),
        .victim_data(a_data),
        .swb_data   (b_data),
        .cmd_valid  (bus_req_valid),
        .cmd_op     (cmd_op),
        .cmd_addr   (bus_req_addr),
        .cmd_data   (bus_req_data)
    );

    assign bus_req_op = cmd_op;

    assign snp_ready    = in_idle;
    assign cpu_ready    = in_idle && !snp_valid;
    assign snp_fire     = snp_valid && snp_ready;
    assign cpu_fire     = cpu_valid && cpu_ready;
    assign cmd_fire     = bus_req_valid && bus_req_ready;
    assign cpu_hit      = cpu_local_hit(a_st, a_match, cpu_write);
    assign victim_dirty = a_dirty && !a_match;
    assign snp_owns     = b_dirty && b_match;
    assign snp_abort    = snp_fire && snp_owns;

    always_comb begin
        ctl_d      = ctl_q;
        wr_en      = 1'b0;
        wr_idx     = idx_a;
        wr_st      = a_st;
        wr_tag_en  = 1'b0;
        wr_tag     = want_a;
        wr_data_en = 1'b0;
        wr_data    = cpu_wdata;
        unique case (ctl_q)
            CT_IDLE: begin
                if (snp_fire) begin
                    if (snp_owns) begin
                        ctl_d = CT_SWB;
                    end else if (b_match) begin
                        wr_en  = 1'b1;
                        wr_idx = idx_b;
                        wr_st  = snoop_next(b_st, snp_op_e);
                    end
                end else if (cpu_fire) begin
                    if (cpu_hit) begin
                        if (cpu_write) begin
                            wr_en      = 1'b1;
                            wr_data_en = 1'b1;
                        end
                    end else begin
                        ctl_d = victim_dirty ? CT_WBACK : CT_MISS;
                    end
                end
            end
            CT_WBACK: if (cmd_fire) ctl_d = CT_MISS;
            CT_MISS:  if (cmd_fire) ctl_d = CT_FILL;
            CT_FILL: begin
                if (bus_fill_valid) begin
                    wr_en      = 1'b1;
                    wr_st      = fill_state(req_wr_q);
                    wr_tag_en  = 1'b1;
                    wr_data_en = 1'b1;
                    wr_data    = req_wr_q ? req_wdata_q : bus_fill_data;
                    ctl_d      = CT_IDLE;
                end
            end
            CT_SWB: begin
                if (cmd_fire) begin
                    wr_en  = 1'b1;
                    wr_idx = idx_b;
                    wr_st  = snoop_next(b_st, swb_op_q);
                    ctl_d  = CT_IDLE;
                end
            end
            default: ctl_d = CT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q       <= CT_IDLE;
            req_wr_q    <= 1'b0;
            req_addr_q  <= '0;
            req_wdata_q <= '0;
            swb_addr_q  <= '0;
            swb_op_q    <= CMD_NONE;
            done_q      <= 1'b0;
            rdata_q     <= '0;
        end else begin
            ctl_q  <= ctl_d;
            done_q <= 1'b0;
            if (snp_fire) begin
                swb_addr_q <= snp_addr;
                swb_op_q   <= snp_op_e;
            end
            if (cpu_fire) begin
                req_wr_q    <= cpu_write;
                req_addr_q  <= cpu_addr;
                req_wdata_q <= cpu_wdata;
                if (cpu_hit) begin
                    done_q  <= 1'b1;
                    rdata_q <= cpu_write ? cpu_wdata : a_data;
                end
            end
            if ((ctl_q == CT_FILL) && bus_fill_valid) begin
                done_q  <= 1'b1;
                rdata_q <= req_wr_q ? req_wdata_q : bus_fill_data;
            end
        end
    end

    assign cpu_done  = done_q;
    assign cpu_rdata = rdata_q;

endmodule

// File: rtl/snp_checker.sv
module snp_checker #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_ready,
    input logic              cpu_done,
    input logic              bus_req_valid,
    input logic              bus_req_ready,
    input logic [1:0]        bus_req_op,
    input logic [ADDR_W-1:0] bus_req_addr,
    input logic [DATA_W-1:0] bus_req_data,
    input logic              snp_valid,
    input logic              snp_ready,
    input logic              snp_abort
);

    a_r11_cmd_hold: assert property (@(posedge clk) disable iff (rst)
        (bus_req_valid && !bus_req_ready) |=>
            (bus_req_valid && $stable(bus_req_op) && $stable(bus_req_addr) && $stable(bus_req_data)));

    a_r11_op_present: assert property (@(posedge clk) disable iff (rst)
        bus_req_valid |-> (bus_req_op != 2'b00));

    a_r9_snoop_first: assert property (@(posedge clk) disable iff (rst)
        snp_valid |-> !cpu_ready);

    a_r7_abort_on_accept: assert property (@(posedge clk) disable iff (rst)
        snp_abort |-> (snp_valid && snp_ready));

    a_r8_abort_then_wback: assert property (@(posedge clk) disable iff (rst)
        snp_abort |=> (bus_req_valid && bus_req_op == 2'b11));

    a_r3_miss_waits_fill: assert property (@(posedge clk) disable iff (rst)
        (bus_req_valid && bus_req_ready && bus_req_op[1] != bus_req_op[0]) |=>
            (!bus_req_valid && !cpu_done));

    a_r12_done_quiet: assert property (@(posedge clk) disable iff (rst)
        cpu_done |-> !bus_req_valid);

endmodule

bind snoop_cache_ctrl snp_checker #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_snp_checker (
    .clk          (clk),
    .rst          (rst),
    .cpu_ready    (cpu_ready),
    .cpu_done     (cpu_done),
    .bus_req_valid(bus_req_valid),
    .bus_req_ready(bus_req_ready),
    .bus_req_op   (bus_req_op),
    .bus_req_addr (bus_req_addr),
    .bus_req_data (bus_req_data),
    .snp_valid    (snp_valid),
    .snp_ready    (snp_ready),
    .snp_abort    (snp_abort)
);

// File: tb/snoop_cache_ctrl_test.sv
module snoop_cache_ctrl_test;

    localparam int AW = 12;
    localparam int DW = 32;
    localparam int NL = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_valid = 1'b0, cpu_write = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_ready, cpu_done;
    logic [DW-1:0] cpu_rdata;
    logic          bus_req_valid;
    logic          bus_req_ready = 1'b0;
    logic [1:0]    bus_req_op;
    logic [AW-1:0] bus_req_addr;
    logic [DW-1:0] bus_req_data;
    logic          bus_fill_valid = 1'b0;
    logic [DW-1:0] bus_fill_data = '0;
    logic          snp_valid = 1'b0;
    logic [1:0]    snp_op = 2'b00;
    logic [AW-1:0] snp_addr = '0;
    logic          snp_ready, snp_abort;

    int vectors = 0;
    int misses  = 0;

    // Behavioural model: 0 = Invalid, 1 = Shared, 2 = Exclusive
    int          m_st  [NL];
    int          m_tag [NL];
    logic [DW-1:0] m_dat [NL];

    always #5 clk = ~clk;

    snoop_cache_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL)) uut (
        .clk(clk), .rst(rst),
        .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_done(cpu_done),
        .cpu_rdata(cpu_rdata),
        .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
        .bus_req_op(bus_req_op), .bus_req_addr(bus_req_addr),
        .bus_req_data(bus_req_data),
        .bus_fill_valid(bus_fill_valid), .bus_fill_data(bus_fill_data),
        .snp_valid(snp_valid), .snp_op(snp_op), .snp_addr(snp_addr),
        .snp_ready(snp_ready), .snp_abort(snp_abort)
    );

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cpu_op(string req, logic wr, logic [AW-1:0] a, logic [DW-1:0] wd);
        int i;
        int t;
        bit hit;
        logic [DW-1:0] fill;
        i = int'(a[1:0]);
        t = int'(a[AW-1:2]);
        hit = (m_st[i] != 0) && (m_tag[i] == t) && (m_st[i] == 2 || !wr);
        fill = 32'hF000_0000 | 32'(a);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_write = wr; cpu_addr = a; cpu_wdata = wd;
        #1 chk(req, "cpu_ready", 64'(cpu_ready), 64'd1);
        @(posedge clk);
        @(negedge clk);
        cpu_valid = 1'b0;
        #1;
        if (hit) begin
            chk(req, "hit done", 64'(cpu_done), 64'd1);
            chk(req, "hit rdata", 64'(cpu_rdata), 64'(wr ? wd : m_dat[i]));
            chk(req, "hit no bus", 64'(bus_req_valid), 64'd0);
            if (wr) m_dat[i] = wd;
        end else begin
            if (m_st[i] == 2 && m_tag[i] != t) begin
                // R5 victim write-back, held one cycle without grant (R11)
                chk(req, "wb valid", 64'(bus_req_valid), 64'd1);
                chk(req, "wb op", 64'(bus_req_op), 64'd3);
                chk(req, "wb addr", 64'(bus_req_addr), 64'((m_tag[i] << 2) | i));
                chk(req, "wb data", 64'(bus_req_data), 64'(m_dat[i]));
                @(negedge clk);
                #1;
                chk("R11", "held op", 64'(bus_req_op), 64'd3);
                chk("R11", "held addr", 64'(bus_req_addr), 64'((m_tag[i] << 2) | i));
                bus_req_ready = 1'b1;
                @(posedge clk);
                @(negedge clk);
                bus_req_ready = 1'b0;
                #1;
            end
            chk(req, "miss valid", 64'(bus_req_valid), 64'd1);
            chk(req, "miss op", 64'(bus_req_op), 64'(wr ? 2 : 1));
            chk(req, "miss addr", 64'(bus_req_addr), 64'(a));
            chk(req, "no done before fill", 64'(cpu_done), 64'd0);
            bus_req_ready = 1'b1;
            @(posedge clk);
            @(negedge clk);
            bus_req_ready = 1'b0;
            #1 chk(req, "fill wait quiet", 64'(bus_req_valid), 64'd0);
            bus_fill_valid = 1'b1; bus_fill_data = fill;
            @(posedge clk);
            @(negedge clk);
            bus_fill_valid = 1'b0;
            #1;
            chk(req, "fill done", 64'(cpu_done), 64'd1);
            chk(req, "fill rdata", 64'(cpu_rdata), 64'(wr ? wd : fill));
            m_st[i] = wr ? 2 : 1;
            m_tag[i] = t;
            m_dat[i] = wr ? wd : fill;
        end
    endtask

    task automatic snoop(string req, logic [1:0] op, logic [AW-1:0] a, bit with_cpu);
        int i;
        int t;
        bit match;
        bit owns;
        i = int'(a[1:0]);
        t = int'(a[AW-1:2]);
        match = (m_st[i] != 0) && (m_tag[i] == t);
        owns = match && (m_st[i] == 2);
        @(negedge clk);
        snp_valid = 1'b1; snp_op = op; snp_addr = a;
        if (with_cpu) begin
            cpu_valid = 1'b1; cpu_write = 1'b0; cpu_addr = a;
        end
        #1;
        chk(req, "snp_ready", 64'(snp_ready), 64'd1);
        chk(req, "snp_abort", 64'(snp_abort), 64'(owns));
        if (with_cpu) chk("R9", "cpu_ready under snoop", 64'(cpu_ready), 64'd0);
        @(posedge clk);
        @(negedge clk);
        snp_valid = 1'b0;
        cpu_valid = 1'b0;
        #1;
        if (owns) begin
            chk(req, "swb valid", 64'(bus_req_valid), 64'd1);
            chk(req, "swb op", 64'(bus_req_op), 64'd3);
            chk(req, "swb addr", 64'(bus_req_addr), 64'(a));
            chk(req, "swb data", 64'(bus_req_data), 64'(m_dat[i]));
            bus_req_ready = 1'b1;
            @(posedge clk);
            @(negedge clk);
            bus_req_ready = 1'b0;
            #1 chk(req, "swb done", 64'(bus_req_valid), 64'd0);
            m_st[i] = (op == 2'b01) ? 1 : 0;
        end else begin
            chk(req, "snoop no bus", 64'(bus_req_valid), 64'd0);
            if (match && op == 2'b10) m_st[i] = 0;
        end
    endtask

    initial begin
        for (int k = 0; k < NL; k++) begin
            m_st[k] = 0; m_tag[k] = 0; m_dat[k] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1", "bus idle", 64'(bus_req_valid), 64'd0);
        chk("R1", "done low", 64'(cpu_done), 64'd0);
        chk("R1", "abort low", 64'(snp_abort), 64'd0);
        chk("R1", "cpu_ready", 64'(cpu_ready), 64'd1);
        chk("R1", "snp_ready", 64'(snp_ready), 64'd1);

        cpu_op("R2", 1'b0, 12'h010, '0);
        cpu_op("R4", 1'b0, 12'h010, '0);
        cpu_op("R3", 1'b1, 12'h010, 32'hA5A5_0001);
        cpu_op("R4", 1'b1, 12'h010, 32'hA5A5_0002);
        cpu_op("R4", 1'b0, 12'h010, '0);
        cpu_op("R5", 1'b0, 12'h014, '0);
        snoop("R10", 2'b01, 12'h014, 1'b0);
        cpu_op("R10", 1'b0, 12'h014, '0);
        snoop("R6", 2'b10, 12'h014, 1'b0);
        cpu_op("R6", 1'b0, 12'h014, '0);
        cpu_op("R3", 1'b1, 12'h021, 32'h1234_5678);
        snoop("R10", 2'b10, 12'h025, 1'b0);
        cpu_op("R4", 1'b0, 12'h021, '0);
        snoop("R7", 2'b01, 12'h021, 1'b0);
        cpu_op("R7", 1'b0, 12'h021, '0);
        cpu_op("R7", 1'b1, 12'h021, 32'hCAFE_0001);
        snoop("R8", 2'b10, 12'h021, 1'b1);
        cpu_op("R8", 1'b0, 12'h021, '0);
        snoop("R9", 2'b01, 12'h333, 1'b1);
        cpu_op("R3", 1'b1, 12'h123, 32'h0BAD_F00D);
        cpu_op("R5", 1'b1, 12'h0A3, 32'h7777_0003);
        cpu_op("R4", 1'b0, 12'h0A3, '0);

        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule